// File: doc/BRIEF.md
# 2x2 Quad Gather Request Expander

This unit sits between a processor's read request and the address translator. A request carries a coordinate pair (x, y), an input identifier, and three qualifiers: whether the 2x2 quad gather is asked for, whether the requester is an input-read client, and whether the addressed format holds more than one channel. With the quad gather in effect, the unit turns the single request into four element fetches on neighbouring coordinates. It then packs the four returned scalars into one four-channel response, so one instruction does the work of four.

Fetches leave one per cycle under a valid/ready handshake. Returned scalars come back in issue order on a plain valid strobe. The packed result is held under its own valid/ready handshake until it is taken. When the quad gather is not in effect, the request passes through as one fetch. A quad request against a multi-channel format issues no fetch and returns an error flag instead. Only one request is handled at a time.

Top module: `quad_gather_expander`

## Requirements
- R1: The quad gather is in effect when the quad, input-client and single-channel conditions all hold (req_quad_i=1, req_input_i=1, req_multi_i=0). It then issues exactly four fetches, in the order (x+1, y), (x, y+1), (x+1, y+1), (x, y).
- R2: In quad mode, the scalar returned for fetch k (k = 0..3, in issue order) lands in channel k. Channel k occupies rsp_data_o bits [16k+15:16k], so c0 is the least significant.
- R3: For a request with req_input_i=0, the quad flag has no effect. One fetch at (x, y) is issued and the response is the pass-through form.
- R4: When req_quad_i=1, req_input_i=1 and req_multi_i=1, no fetch is issued. The response has rsp_fmt_err_o=1 and all-zero data. rsp_fmt_err_o is 0 for every other response.
- R5: Neighbour coordinates are computed modulo 2^12, so 4095+1 gives 0. rsp_wrap_o is 1 exactly when the quad gather is in effect and x or y equals 4095.
- R6: While fet_valid_o is high and fet_ready_i is low, fet_valid_o stays high and the fetch coordinates and identifier hold steady. At most one fetch is issued per cycle.
- R7: When the quad gather is not in effect and no error applies, one fetch at (x, y) is issued. The returned scalar goes to c0, and c1 to c3 are zero.
- R8: Once a request is accepted, req_ready_o stays low until the response is accepted. A request presented meanwhile is not taken and issues no fetch. An unaccepted response holds its data.
- R9: After reset, req_ready_o=1, fet_valid_o=0 and rsp_valid_o=0.
- R10: Every fetch carries the identifier of the request it belongs to.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Unit idle, request taken on this cycle |
| req_x_i | input | 12 | Column coordinate |
| req_y_i | input | 12 | Row coordinate |
| req_id_i | input | 4 | Input identifier |
| req_quad_i | input | 1 | 2x2 quad gather asked for |
| req_input_i | input | 1 | Requester is an input-read client |
| req_multi_i | input | 1 | Addressed format has more than one channel |
| fet_valid_o | output | 1 | Element fetch present |
| fet_ready_i | input | 1 | Fetch taken |
| fet_x_o | output | 12 | Fetch column |
| fet_y_o | output | 12 | Fetch row |
| fet_id_o | output | 4 | Fetch identifier |
| ret_valid_i | input | 1 | Returned scalar present, in issue order |
| ret_data_i | input | 16 | Returned scalar |
| rsp_valid_o | output | 1 | Packed response present |
| rsp_ready_i | input | 1 | Response taken |
| rsp_data_o | output | 64 | Packed channels, c0 in the low bits |
| rsp_wrap_o | output | 1 | A neighbour coordinate wrapped |
| rsp_fmt_err_o | output | 1 | Quad asked for on a multi-channel format |

## Verification
A wrong issue counter shows up at once on the fetch port: a coordinate appears out of order, or a fourth or fifth fetch appears in the cycle after it should have stopped. A wrong return counter instead puts a correct scalar into the wrong channel slot. It can also leave the unit waiting forever, which shows as a response that never arrives. A mode latched wrongly at acceptance shows as the wrong fetch count within the first few cycles of a request, well before the response. A busy state that clears early lets a second request slip in while the response is still held.

// File: rtl/qg_pkg.sv
package qg_pkg;
  localparam int QG_LANES = 4;
  localparam int QG_IDX_W = $clog2(QG_LANES);

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_ISSUE   = 2'd1,
    ST_COLLECT = 2'd2,
    ST_RESP    = 2'd3
  } qg_state_e;

  // neighbour step per fetch slot: 0:(+1,0) 1:(0,+1) 2:(+1,+1) 3:(0,0)
  function automatic logic qg_step_x(logic [QG_IDX_W-1:0] idx);
    return (idx == 2'd0) || (idx == 2'd2);
  endfunction

  function automatic logic qg_step_y(logic [QG_IDX_W-1:0] idx);
    return (idx == 2'd1) || (idx == 2'd2);
  endfunction
endpackage

// File: rtl/qg_coord_gen.sv
module qg_coord_gen
  import qg_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic [CW-1:0]       base_x_i,
  input  logic [CW-1:0]       base_y_i,
  input  logic [QG_IDX_W-1:0] idx_i,
  input  logic                quad_i,
  output logic [CW-1:0]       x_o,
  output logic [CW-1:0]       y_o,
  output logic                wrap_o
);
  logic inc_x, inc_y;

  always_comb begin
    inc_x  = quad_i & qg_step_x(idx_i);
    inc_y  = quad_i & qg_step_y(idx_i);
    x_o    = base_x_i + {{(CW-1){1'b0}}, inc_x};
    y_o    = base_y_i + {{(CW-1){1'b0}}, inc_y};
    wrap_o = quad_i & ((&base_x_i) | (&base_y_i));
  end
endmodule

// File: rtl/qg_pack.sv
module qg_pack
  import qg_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   clr_i,
  input  logic                   wr_i,
  input  logic [QG_IDX_W-1:0]    idx_i,
  input  logic [DW-1:0]          data_i,
  output logic [QG_LANES*DW-1:0] data_o
);
  for (genvar g = 0; g < QG_LANES; g++) begin : g_lane
    logic [DW-1:0] lane_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            lane_q <= '0;
      else if (clr_i)                         lane_q <= '0;
      else if (wr_i && (idx_i == QG_IDX_W'(g))) lane_q <= data_i;
    end
    assign data_o[g*DW +: DW] = lane_q;
  end
endmodule

// File: rtl/qg_ctrl.sv
module qg_ctrl
  import qg_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  input  logic                quad_i,
  input  logic                err_i,
  output logic                req_ready_o,
  output logic                accept_o,
  output logic                quad_o,
  output logic                fet_valid_o,
  input  logic                fet_ready_i,
  output logic [QG_IDX_W-1:0] fet_idx_o,
  input  logic                ret_valid_i,
  output logic                ret_fire_o,
  output logic [QG_IDX_W-1:0] ret_idx_o,
  output logic                rsp_valid_o,
  input  logic                rsp_ready_i
);
  qg_state_e             state_q, state_d;
  logic [QG_IDX_W-1:0]   iss_q, ret_q, last;
  logic                  quad_q, fet_fire;

  assign req_ready_o = (state_q == ST_IDLE);
  assign accept_o    = req_ready_o & req_valid_i;
  assign quad_o      = quad_q;
  assign fet_valid_o = (state_q == ST_ISSUE);
  assign fet_fire    = fet_valid_o & fet_ready_i;
  assign ret_fire_o  = ret_valid_i & ((state_q == ST_ISSUE) | (state_q == ST_COLLECT));
  assign rsp_valid_o = (state_q == ST_RESP);
  assign fet_idx_o   = iss_q;
  assign ret_idx_o   = ret_q;
  assign last        = quad_q ? QG_IDX_W'(QG_LANES-1) : '0;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (accept_o) state_d = err_i ? ST_RESP : ST_ISSUE;
      ST_ISSUE: begin
        if (ret_fire_o && ret_q == last)      state_d = ST_RESP;
        else if (fet_fire && iss_q == last)   state_d = ST_COLLECT;
      end
      ST_COLLECT: if (ret_fire_o && ret_q == last) state_d = ST_RESP;
      ST_RESP:    if (rsp_ready_i) state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      iss_q   <= '0;
      ret_q   <= '0;
      quad_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept_o) begin
        iss_q  <= '0;
        ret_q  <= '0;
        quad_q <= quad_i;
      end else begin
        if (fet_fire)   iss_q <= iss_q + 1'b1;
        if (ret_fire_o) ret_q <= ret_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/quad_gather_expander.sv
module quad_gather_expander
  import qg_pkg::*;
#(
  parameter int CW = 12,
  parameter int DW = 16,
  parameter int IW = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_valid_i,
  output logic                   req_ready_o,
  input  logic [CW-1:0]          req_x_i,
  input  logic [CW-1:0]          req_y_i,
  input  logic [IW-1:0]          req_id_i,
  input  logic                   req_quad_i,
  input  logic                   req_input_i,
  input  logic                   req_multi_i,
  output logic                   fet_valid_o,
  input  logic                   fet_ready_i,
  output logic [CW-1:0]          fet_x_o,
  output logic [CW-1:0]          fet_y_o,
  output logic [IW-1:0]          fet_id_o,
  input  logic                   ret_valid_i,
  input  logic [DW-1:0]          ret_data_i,
  output logic                   rsp_valid_o,
  input  logic                   rsp_ready_i,
  output logic [QG_LANES*DW-1:0] rsp_data_o,
  output logic                   rsp_wrap_o,
  output logic                   rsp_fmt_err_o
);
  logic                quad_eff, fmt_err, accept, quad_q, ret_fire, wrap;
  logic [QG_IDX_W-1:0] fet_idx, ret_idx;
  logic [CW-1:0]       x_q, y_q;
  logic [IW-1:0]       id_q;
  logic                err_q;

  assign quad_eff = req_quad_i & req_input_i & ~req_multi_i;
  assign fmt_err  = req_quad_i & req_input_i &  req_multi_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q   <= '0;
      y_q   <= '0;
      id_q  <= '0;
      err_q <= 1'b0;
    end else if (accept) begin
      x_q   <= req_x_i;
      y_q   <= req_y_i;
      id_q  <= req_id_i;
      err_q <= fmt_err;
    end
  end

  qg_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .quad_i      (quad_eff),
    .err_i       (fmt_err),
    .req_ready_o (req_ready_o),
    .accept_o    (accept),
    .quad_o      (quad_q),
    .fet_valid_o (fet_valid_o),
    .fet_ready_i (fet_ready_i),
    .fet_idx_o   (fet_idx),
    .ret_valid_i (ret_valid_i),
    .ret_fire_o  (ret_fire),
    .ret_idx_o   (ret_idx),
    .rsp_valid_o (rsp_valid_o),
    .rsp_ready_i (rsp_ready_i)
  );

  qg_coord_gen #(.CW(CW)) u_coord (
    .base_x_i (x_q),
    .base_y_i (y_q),
    .idx_i    (fet_idx),
    .quad_i   (quad_q),
    .x_o      (fet_x_o),
    .y_o      (fet_y_o),
    .wrap_o   (wrap)
  );

  qg_pack #(.DW(DW)) u_pack (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (accept),
    .wr_i   (ret_fire),
    .idx_i  (ret_idx),
    .data_i (ret_data_i),
    .data_o (rsp_data_o)
  );

  assign fet_id_o      = id_q;
  assign rsp_wrap_o    = rsp_valid_o & wrap;
  assign rsp_fmt_err_o = rsp_valid_o & err_q;
endmodule

// File: rtl/qg_checker.sv
module qg_checker #(
  parameter int CW = 12,
  parameter int DW = 16,
  parameter int IW = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_valid_i,
  input logic            req_ready_o,
  input logic            fet_valid_o,
  input logic            fet_ready_i,
  input logic [CW-1:0]   fet_x_o,
  input logic [CW-1:0]   fet_y_o,
  input logic [IW-1:0]   fet_id_o,
  input logic            rsp_valid_o,
  input logic            rsp_ready_i,
  input logic [4*DW-1:0] rsp_data_o,
  input logic            rsp_fmt_err_o
);
  logic [2:0] fet_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         fet_cnt <= '0;
    else if (req_valid_i && req_ready_o) fet_cnt <= '0;
    else if (fet_valid_o && fet_ready_i) fet_cnt <= fet_cnt + 1'b1;
  end

  a_r6_fet_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fet_valid_o && !fet_ready_i |=> fet_valid_o && $stable(fet_x_o) && $stable(fet_y_o) && $stable(fet_id_o));

  a_r8_busy_no_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fet_valid_o || rsp_valid_o) |-> !req_ready_o);

  a_r8_rsp_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ready_i |=> rsp_valid_o && $stable(rsp_data_o));

  a_r1_max_four: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fet_valid_o |-> fet_cnt < 3'd4);

  a_r4_err_no_fetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_fmt_err_o |-> fet_cnt == 3'd0 && rsp_data_o == '0);

  a_r6_one_side: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fet_valid_o && rsp_valid_o));
endmodule

bind quad_gather_expander qg_checker #(.CW(CW), .DW(DW), .IW(IW)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_valid_i   (req_valid_i),
  .req_ready_o   (req_ready_o),
  .fet_valid_o   (fet_valid_o),
  .fet_ready_i   (fet_ready_i),
  .fet_x_o       (fet_x_o),
  .fet_y_o       (fet_y_o),
  .fet_id_o      (fet_id_o),
  .rsp_valid_o   (rsp_valid_o),
  .rsp_ready_i   (rsp_ready_i),
  .rsp_data_o    (rsp_data_o),
  .rsp_fmt_err_o (rsp_fmt_err_o)
);

// File: tb/quad_gather_expander_tb.sv
module quad_gather_expander_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        req_valid = 0, req_quad = 0, req_input = 0, req_multi = 0;
  logic [11:0] req_x = 0, req_y = 0;
  logic [3:0]  req_id = 0;
  logic        req_ready, fet_valid, fet_ready = 0, ret_valid = 0, rsp_valid, rsp_ready = 0;
  logic [11:0] fet_x, fet_y;
  logic [3:0]  fet_id;
  logic [15:0] ret_data = 0;
  logic [63:0] rsp_data;
  logic        rsp_wrap, rsp_err;

  quad_gather_expander u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_x_i(req_x), .req_y_i(req_y), .req_id_i(req_id),
    .req_quad_i(req_quad), .req_input_i(req_input), .req_multi_i(req_multi),
    .fet_valid_o(fet_valid), .fet_ready_i(fet_ready),
    .fet_x_o(fet_x), .fet_y_o(fet_y), .fet_id_o(fet_id),
    .ret_valid_i(ret_valid), .ret_data_i(ret_data),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready),
    .rsp_data_o(rsp_data), .rsp_wrap_o(rsp_wrap), .rsp_fmt_err_o(rsp_err)
  );

  int checks = 0, fails = 0, cyc = 0, ncyc = 0;

  typedef struct packed {
    logic [11:0] x; logic [11:0] y; logic [3:0] id;
    logic quad; logic inp; logic multi; logic ex_wrap; logic ex_err;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{12'd5,    12'd9,    4'd1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    '{12'd100,  12'd200,  4'd2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    '{12'd4095, 12'd7,    4'd3, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
    '{12'd30,   12'd4095, 4'd4, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
    '{12'd4095, 12'd4095, 4'd5, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
    '{12'd10,   12'd10,   4'd6, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    '{12'd11,   12'd12,   4'd7, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1},
    '{12'd50,   12'd60,   4'd8, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
    '{12'd0,    12'd0,    4'd9, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}
  };

  function automatic logic [15:0] mem_val(logic [11:0] x, logic [11:0] y, logic [3:0] id);
    return {id, x[5:0], y[5:0]} ^ 16'h5a5a;
  endfunction

  // fetch log and memory model, one-cycle return latency
  logic [11:0] log_x [64];
  logic [11:0] log_y [64];
  logic [3:0]  log_id [64];
  int          log_n = 0;
  logic        pend = 0;
  logic [15:0] pend_data = 0;

  always @(negedge clk) begin
    ncyc++;
    ret_valid = pend;
    ret_data  = pend_data;
    pend      = 0;
    fet_ready = (ncyc % 3) != 2;
    if (rst_n && fet_valid && fet_ready) begin
      if (log_n < 64) begin
        log_x[log_n] = fet_x; log_y[log_n] = fet_y; log_id[log_n] = fet_id;
      end
      log_n++;
      pend = 1;
      pend_data = mem_val(fet_x, fet_y, fet_id);
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++;
      checks++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 20000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic run_vec(input vec_t v, input int hold);
    int base, n, waits;
    bit eff, er;
    string tag;
    logic [63:0] snap;
    eff = v.quad & v.inp & ~v.multi;
    er  = v.quad & v.inp & v.multi;
    n   = er ? 0 : (eff ? 4 : 1);
    tag = er ? "R4" : (eff ? "R1" : (v.inp ? "R7" : "R3"));
    @(negedge clk);
    base = log_n;
    req_x = v.x; req_y = v.y; req_id = v.id;
    req_quad = v.quad; req_input = v.inp; req_multi = v.multi;
    req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    waits = 0;
    while (!rsp_valid && waits < 200) begin @(negedge clk); waits++; end
    chk(rsp_valid, "R8", {63'd0, rsp_valid}, 64'd1);
    snap = rsp_data;
    for (int h = 0; h < hold; h++) begin
      req_x = v.x + 12'd3; req_quad = 1; req_input = 1; req_multi = 0;
      req_valid = 1;
      @(negedge clk);
      chk(req_ready == 0, "R8", {63'd0, req_ready}, 64'd0);
      chk(rsp_data == snap && rsp_valid, "R8", rsp_data, snap);
    end
    req_valid = 0;
    chk(log_n - base == n, tag, 64'(log_n - base), 64'(n));
    for (int k = 0; k < n && k < 4; k++) begin
      logic [11:0] ex, ey;
      ex = v.x; ey = v.y;
      if (eff) begin
        if (k == 0 || k == 2) ex = v.x + 12'd1;
        if (k == 1 || k == 2) ey = v.y + 12'd1;
      end
      chk(log_x[base+k] == ex && log_y[base+k] == ey, v.ex_wrap ? "R5" : tag,
          {40'd0, log_x[base+k], log_y[base+k]}, {40'd0, ex, ey});
      chk(log_id[base+k] == v.id, "R10", 64'(log_id[base+k]), 64'(v.id));
    end
    for (int k = 0; k < 4; k++) begin
      logic [15:0] ed;
      logic [11:0] ex, ey;
      ex = v.x; ey = v.y;
      if (k == 0 || k == 2) ex = v.x + 12'd1;
      if (k == 1 || k == 2) ey = v.y + 12'd1;
      if (er)       ed = 16'd0;
      else if (eff) ed = mem_val(ex, ey, v.id);
      else          ed = (k == 0) ? mem_val(v.x, v.y, v.id) : 16'd0;
      chk(rsp_data[16*k +: 16] == ed, er ? "R4" : (eff ? "R2" : tag),
          64'(rsp_data[16*k +: 16]), 64'(ed));
    end
    chk(rsp_wrap == v.ex_wrap, "R5", {63'd0, rsp_wrap}, {63'd0, v.ex_wrap});
    chk(rsp_err == v.ex_err, "R4", {63'd0, rsp_err}, {63'd0, v.ex_err});
    rsp_ready = 1;
    @(negedge clk);
    rsp_ready = 0;
    chk(!rsp_valid && req_ready, "R8", {62'd0, rsp_valid, req_ready}, 64'd1);
    chk(log_n - base == n, "R8", 64'(log_n - base), 64'(n));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(req_ready == 1, "R9", {63'd0, req_ready}, 64'd1);
    chk(fet_valid == 0 && rsp_valid == 0, "R9", {62'd0, fet_valid, rsp_valid}, 64'd0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    for (int i = 0; i < NV; i++) run_vec(VEC[i], 0);
    // R8: response held under back-pressure, competing request refused
    run_vec(VEC[0], 3);
    run_vec(VEC[6], 2);
    // R3: non-input client with wrap-prone coordinates stays single, no wrap flag
    run_vec('{12'd4095, 12'd4095, 4'd10, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, 0);
    // R6: fetch stream after back-to-back requests
    run_vec('{12'd2047, 12'd1, 4'd15, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule